// File: doc/BRIEF.md
# Multi-Level Key Code Debouncer

This block sits behind the converter that measures the resistance on a remote-control sense line. Each clock it receives an 8-bit code for that resistance. It sorts the code into a class: one of the keys, a jack-inserted class or a jack-removed class. A code that falls between the allowed bands is treated as invalid. The block reports a class change only after that class has held without interruption for a programmable number of time-base ticks. Shorter excursions are rejected as chatter.

The result leaves the block as a one-cycle event strobe. Beside it is an 8-bit value carrying the class that is now stable, ready to be pushed into an event FIFO. A parameter selects one of two class sets:
- a 30-key set, in which each key owns a narrow band of codes;
- a 6-key set, in which the code value itself is the class.

The `tick` input sets the debounce time base. For example, one tick per millisecond with the default of 18 ticks gives an 18 ms stability window.

Top module: `key_debounce`

## Requirements
- R1: With SIX_KEY=0, key index n (0..29) is reported as class n and accepts these inclusive code bands: 0:0-1, 1:11-13, 2:19-21, 3:27-30, 4:35-38, 5:42-46, 6:50-53, 7:58-62, 8:66-70, 9:74-78, 10:82-86, 11:90-94, 12:98-102, 13:105-110, 14:114-119, 15:123-127, 16:130-135, 17:137-142, 18:146-150, 19:154-159, 20:162-166, 21:170-174, 22:178-182, 23:186-190, 24:194-198, 25:202-206, 26:211-214, 27:218-222, 28:226-229, 29:235-237.
- R2: With SIX_KEY=0, codes 243-245 are reported as class 30 (jack inserted) and codes 254-255 as class 31 (jack removed).
- R3: With SIX_KEY=1, a code value v in 0..7 is class v: values 0-5 are keys, 6 is jack inserted and 7 is jack removed. Codes of 8 and above are invalid.
- R4: A code outside every band never produces an event. Such a code restarts the stability count and leaves the reported class unchanged.
- R5: A valid class becomes stable once it has been present on every clock since its first cycle and DEBOUNCE_TICKS ticks have then been sampled. A tick sampled on that first cycle is not counted. `evt_o` rises one cycle after the clock edge that samples the last of those ticks.
- R6: A class held for fewer than DEBOUNCE_TICKS counted ticks before the code changes produces no event.
- R7: Every change of the stable class produces an event, whether to another key, a jack class or a release. A class equal to the current stable class produces none.
- R8: After reset, `evt_o` is 0 and `evt_code_o` is the jack-removed class (31, or 7 with SIX_KEY=1). No event occurs until a different class becomes stable.
- R9: `evt_o` is high for single cycles only. `evt_code_o` holds the stable class, zero-extended to 8 bits, and changes only together with `evt_o`.
- R10: An event is only raised on a clock edge that samples `tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Debounce time-base pulse, one cycle wide |
| code_i | input | 8 | Sampled resistance code |
| evt_o | output | 1 | One-cycle strobe: a new class is stable |
| evt_code_o | output | 8 | Current stable class, zero-extended |

## Verification
The bound checker watches five properties on every cycle: the strobe lasts one cycle, the strobe coincides with a sampled tick, the reported class moves only with a strobe, each strobe carries a different class, and the class value stays within the selected set. Only the bench's scenarios can show the rest:
- the band decoding at the edges of each band;
- chatter rejection;
- the restart caused by invalid codes sprinkled into a held key;
- the exact cycle on which the debounce window closes.

A cycle-level model built from the requirements checks these against long random code sequences.

// File: rtl/key_debounce_pkg.sv
package key_debounce_pkg;
  localparam int CODE_W = 8;
  localparam int CLS_W = 5;
  localparam int NUM_BANDS = 32;

  typedef logic [CLS_W-1:0] cls_t;

  // Inclusive code band {low, high} for each class of the 30-key set.
  function automatic logic [15:0] band(input int unsigned idx);
    case (idx)
      0: band = {8'd0, 8'd1};
      1: band = {8'd11, 8'd13};
      2: band = {8'd19, 8'd21};
      3: band = {8'd27, 8'd30};
      4: band = {8'd35, 8'd38};
      5: band = {8'd42, 8'd46};
      6: band = {8'd50, 8'd53};
      7: band = {8'd58, 8'd62};
      8: band = {8'd66, 8'd70};
      9: band = {8'd74, 8'd78};
      10: band = {8'd82, 8'd86};
      11: band = {8'd90, 8'd94};
      12: band = {8'd98, 8'd102};
      13: band = {8'd105, 8'd110};
      14: band = {8'd114, 8'd119};
      15: band = {8'd123, 8'd127};
      16: band = {8'd130, 8'd135};
      17: band = {8'd137, 8'd142};
      18: band = {8'd146, 8'd150};
      19: band = {8'd154, 8'd159};
      20: band = {8'd162, 8'd166};
      21: band = {8'd170, 8'd174};
      22: band = {8'd178, 8'd182};
      23: band = {8'd186, 8'd190};
      24: band = {8'd194, 8'd198};
      25: band = {8'd202, 8'd206};
      26: band = {8'd211, 8'd214};
      27: band = {8'd218, 8'd222};
      28: band = {8'd226, 8'd229};
      29: band = {8'd235, 8'd237};
      30: band = {8'd243, 8'd245};
      default: band = {8'd254, 8'd255};
    endcase
  endfunction
endpackage

// File: rtl/key_band_classifier.sv
module key_band_classifier
  import key_debounce_pkg::*;
#(
  parameter bit SIX_KEY = 1'b0
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              valid_o,
  output cls_t              cls_o
);
  generate
    if (SIX_KEY) begin : g_six
      // R3: value is the class, anything of 8 or more is invalid
      assign valid_o = (code_i[CODE_W-1:3] == '0);
      assign cls_o   = {{(CLS_W-3){1'b0}}, code_i[2:0]};
    end else begin : g_thirty
      logic [NUM_BANDS-1:0] hit;
      for (genvar i = 0; i < NUM_BANDS; i++) begin : g_band
        localparam logic [15:0] BND = band(i);
        localparam logic [7:0] LO = BND[15:8];
        localparam logic [7:0] HI = BND[7:0];
        if (LO == 8'd0) begin : g_lo0
          assign hit[i] = (code_i <= HI);
        end else if (HI == 8'hFF) begin : g_hi_top
          assign hit[i] = (code_i >= LO);
        end else begin : g_mid
          assign hit[i] = (code_i >= LO) && (code_i <= HI);
        end
      end
      // R1/R2: bands are disjoint, so a plain encoder is enough
      always_comb begin
        valid_o = 1'b0;
        cls_o   = '0;
        for (int i = 0; i < NUM_BANDS; i++) begin
          if (hit[i]) begin
            valid_o = 1'b1;
            cls_o   = cls_t'(i);
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/class_hold_timer.sv
module class_hold_timer
  import key_debounce_pkg::*;
#(
  parameter int DEBOUNCE_TICKS = 18
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic valid_i,
  input  cls_t cls_i,
  output logic held_o,
  output cls_t cand_o
);
  localparam int CNT_W = (DEBOUNCE_TICKS > 1) ? $clog2(DEBOUNCE_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DEBOUNCE_TICKS - 1);

  cls_t             cand_q, cand_n;
  logic             cv_q, cv_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cand_n = cand_q;
    cv_n   = cv_q;
    cnt_n  = cnt_q;
    held_o = 1'b0;
    if (!valid_i) begin
      // R4: invalid code restarts the window
      cv_n  = 1'b0;
      cnt_n = '0;
    end else if (!cv_q || (cls_i != cand_q)) begin
      cand_n = cls_i;
      cv_n   = 1'b1;
      cnt_n  = '0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        held_o = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q <= '0;
      cv_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cand_q <= cand_n;
      cv_q   <= cv_n;
      cnt_q  <= cnt_n;
    end
  end

  assign cand_o = cand_q;
endmodule

// File: rtl/key_debounce.sv
module key_debounce
  import key_debounce_pkg::*;
#(
  parameter bit SIX_KEY = 1'b0,
  parameter int DEBOUNCE_TICKS = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CODE_W-1:0] code_i,
  output logic              evt_o,
  output logic [CODE_W-1:0] evt_code_o
);
  localparam cls_t REMOVED_CLS = SIX_KEY ? cls_t'(7) : cls_t'(31);

  logic rs1_q, rs2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  logic cls_vld, held;
  cls_t cls, cand;

  key_band_classifier #(.SIX_KEY(SIX_KEY)) u_cls (
    .code_i (code_i),
    .valid_o(cls_vld),
    .cls_o  (cls)
  );

  class_hold_timer #(.DEBOUNCE_TICKS(DEBOUNCE_TICKS)) u_hold (
    .clk    (clk),
    .rst_ni (rs2_q),
    .tick_i (tick),
    .valid_i(cls_vld),
    .cls_i  (cls),
    .held_o (held),
    .cand_o (cand)
  );

  cls_t stable_q, stable_n;
  logic evt_q, evt_n;

  always_comb begin
    evt_n    = held && (cand != stable_q);
    stable_n = evt_n ? cand : stable_q;
  end

  always_ff @(posedge clk or negedge rs2_q) begin
    if (!rs2_q) begin
      stable_q <= REMOVED_CLS;
      evt_q    <= 1'b0;
    end else begin
      stable_q <= stable_n;
      evt_q    <= evt_n;
    end
  end

  assign evt_o      = evt_q;
  assign evt_code_o = {{(CODE_W-CLS_W){1'b0}}, stable_q};
endmodule

// File: rtl/key_debounce_chk.sv
module key_debounce_chk
  import key_debounce_pkg::*;
#(
  parameter bit SIX_KEY = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              evt_o,
  input logic [CODE_W-1:0] evt_code_o
);
  localparam int TOP_CLS = SIX_KEY ? 7 : 31;

  p_evt_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> !evt_o);

  p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_o |-> $stable(evt_code_o));

  p_evt_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> (evt_code_o != $past(evt_code_o)));

  p_evt_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> $past(tick));

  p_class_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(evt_code_o) <= TOP_CLS);
endmodule

bind key_debounce key_debounce_chk #(.SIX_KEY(SIX_KEY)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .evt_o     (evt_o),
  .evt_code_o(evt_code_o)
);

// File: tb/sim_key_debounce.sv
`timescale 1ns/1ps
module sim_key_debounce;
  localparam int DEB = 5;
  localparam int LO [32] = '{0, 11, 19, 27, 35, 42, 50, 58, 66, 74, 82, 90, 98, 105, 114, 123,
                             130, 137, 146, 154, 162, 170, 178, 186, 194, 202, 211, 218, 226, 235, 243, 254};
  localparam int HI [32] = '{1, 13, 21, 30, 38, 46, 53, 62, 70, 78, 86, 94, 102, 110, 119, 127,
                             135, 142, 150, 159, 166, 174, 182, 190, 198, 206, 214, 222, 229, 237, 245, 255};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [7:0] code0 = 8'd255;
  logic [7:0] code1 = 8'd7;
  logic evt0, evt1;
  logic [7:0] ecode0, ecode1;

  always #2 clk = ~clk;

  key_debounce #(.SIX_KEY(1'b0), .DEBOUNCE_TICKS(DEB)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .code_i(code0), .evt_o(evt0), .evt_code_o(ecode0));
  key_debounce #(.SIX_KEY(1'b1), .DEBOUNCE_TICKS(DEB)) u1 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .code_i(code1), .evt_o(evt1), .evt_code_o(ecode1));

  int errs = 0, checks = 0;
  int ev0 = 0, ev1 = 0, last0 = 31, last1 = 7;
  int live = 0, phase = 0;
  bit rand_tick = 0, prev_tick = 0;
  // model of u0 built from the requirements
  bit m_cv = 0, m_evt = 0;
  int m_cand = 0, m_cnt = 0, m_stable = 31;

  function automatic int ref_class(input int c);
    for (int i = 0; i < 32; i++)
      if (c >= LO[i] && c <= HI[i]) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_step(input int c, input bit t);
    int k;
    k = ref_class(c);
    m_evt = 0;
    if (k < 0) begin
      m_cv = 0; m_cnt = 0;
    end else if (!m_cv || k != m_cand) begin
      m_cand = k; m_cv = 1; m_cnt = 0;
    end else if (t) begin
      if (m_cnt == DEB - 1) begin
        if (k != m_stable) begin m_stable = k; m_evt = 1; end
      end else m_cnt++;
    end
  endtask

  task automatic cyc(input int c0, input int c1);
    code0 = 8'(c0);
    code1 = 8'(c1);
    tick = rand_tick ? ($urandom % 3 == 0) : (phase == 3);
    phase = (phase + 1) % 4;
    @(posedge clk);
    prev_tick = tick;
    if (live >= 2) model_step(c0, tick); else live++;
    @(negedge clk);
    chk(evt0 == m_evt, "R5 event timing", int'(evt0), int'(m_evt));
    chk(int'(ecode0) == m_stable, "R9 stable class", int'(ecode0), m_stable);
    if (evt0) begin
      ev0++; last0 = int'(ecode0);
      chk(prev_tick, "R10 event on tick", 0, 1);
    end
    if (evt1) begin ev1++; last1 = int'(ecode1); end
  endtask

  task automatic hold(input int n, input int c0, input int c1);
    for (int i = 0; i < n; i++) cyc(c0, c1);
  endtask

  bit done = 0;
  initial begin
    #(4 * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int b0, b1;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!evt0 && ecode0 == 8'd31, "R8 reset class 30-key", int'(ecode0), 31);
    chk(!evt1 && ecode1 == 8'd7, "R8 reset class 6-key", int'(ecode1), 7);
    rst_n = 1'b1;
    live = 0;
    b0 = ev0; b1 = ev1;
    hold(40, 255, 7);
    chk(ev0 == b0 && ev1 == b1, "R8 no event for reset class", ev0 - b0, 0);
    hold(40, 28, 5);
    chk(ev0 == b0 + 1 && last0 == 3, "R1 key 3 from code 28", last0, 3);
    chk(ev1 == b1 + 1 && last1 == 5, "R3 six-key code 5", last1, 5);
    b0 = ev0;
    hold(12, 12, 5);
    hold(30, 28, 5);
    chk(ev0 == b0 && ecode0 == 8'd3, "R6 chatter ignored", ev0 - b0, 0);
    b0 = ev0; b1 = ev1;
    hold(40, 8, 9);
    chk(ev0 == b0 && ecode0 == 8'd3, "R4 invalid code no event", int'(ecode0), 3);
    chk(ev1 == b1 && ecode1 == 8'd5, "R3 six-key code 9 invalid", int'(ecode1), 5);
    for (int r = 0; r < 4; r++) begin
      hold(16, 12, 5);
      cyc(240, 5);
    end
    chk(ev0 == b0 && ecode0 == 8'd3, "R4 invalid restarts window", ev0 - b0, 0);
    hold(40, 244, 6);
    chk(last0 == 30, "R2 jack inserted", last0, 30);
    chk(last1 == 6, "R3 six-key jack inserted", last1, 6);
    hold(40, 254, 6);
    chk(last0 == 31, "R2 jack removed", last0, 31);
    hold(40, 237, 6);
    chk(last0 == 29, "R1 key 29 upper edge", last0, 29);
    hold(40, 0, 6);
    chk(last0 == 0, "R7 change to key 0", last0, 0);
    b0 = ev0;
    hold(40, 1, 6);
    chk(ev0 == b0, "R7 same class no event", ev0 - b0, 0);
    hold(40, 2, 6);
    chk(ev0 == b0 && ecode0 == 8'd0, "R4 code 2 invalid", int'(ecode0), 0);
    rand_tick = 1;
    b0 = ev0;
    for (int s = 0; s < 400; s++) begin
      int c, k, n;
      if ($urandom % 4 == 0) c = int'($urandom % 256);
      else begin
        k = int'($urandom % 32);
        c = LO[k] + int'($urandom % (HI[k] - LO[k] + 1));
      end
      n = 1 + int'($urandom % 40);
      hold(n, c, int'($urandom % 10));
    end
    chk(ev0 > b0 + 20, "R7 random run produced events", ev0 - b0, 21);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule